// File: doc/BRIEF.md
# Receive Signaling Code Store

This block holds the current signaling code for every time slot of one receive link. An upstream extractor delivers signaling nibbles together with a time-slot index and a valid strobe. Each nibble is reduced to the bits that the programmed signaling state mode uses. In 16-state mode all four bits (A, B, C, D) are kept. In 4-state mode only A and B are kept, and in 2-state mode only A is kept. The reduced code is then written into that slot's register.

When debounce is switched on, a slot's register changes only after the same reduced code has arrived on two consecutive samples for that slot. Each slot keeps its own last-seen code for this comparison. A registered read port returns, one cycle after a slot index is presented, a word that packs the current state mode with the stored code.

Top module: `sig_code_store`

## Requirements
- R1: After reset, every slot's stored code and every last-seen code is 0, so a read of any slot returns code bits 3:0 = 0.
- R2: With mode 2'b00 (16-state), a written code keeps A in bit 0, B in bit 1, C in bit 2 and D in bit 3.
- R3: With mode 2'b01 (4-state), bits 3:2 (C, D) are stored as 0 and bits 1:0 are kept.
- R4: With mode 2'b11 (2-state), and likewise with the unused mode 2'b10, bits 3:1 are stored as 0 and only bit 0 (A) is kept.
- R5: A read presents `rd_slot_i` and returns, on the next clock, a word with bits 6:5 = the mode in force at that clock edge, bit 4 = 0, and bits 3:0 = the slot's stored code.
- R6: With debounce off, every sample with `in_valid_i` high writes its reduced code into its slot, and the next read of that slot returns it.
- R7: With debounce on, a slot is updated only when its reduced code equals the reduced code of the previous valid sample for that same slot. Samples for other slots in between do not break the pair.
- R8: The mode reduction is applied before the debounce comparison, so samples that differ only in masked-off bits count as the same code.
- R9: When a write and a read address the same slot in the same cycle, the read returns the value held before the write.
- R10: A cycle with `in_valid_i` low changes neither a stored code nor a last-seen code, whatever the slot and code inputs carry.
- R11: The last-seen code of a slot is updated on every valid sample, including while debounce is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Signaling state mode: 00 = 16-state, 01 = 4-state, 11 (or 10) = 2-state |
| debounce_en_i | input | 1 | 1 = require two matching consecutive samples before an update |
| in_valid_i | input | 1 | Strobe marking a valid extracted signaling sample |
| in_slot_i | input | 5 | Time-slot index of the sample |
| in_code_i | input | 4 | Extracted code, A in bit 0 through D in bit 3 |
| rd_slot_i | input | 5 | Time slot to read |
| rd_data_o | output | 7 | Registered read word: {mode, 1'b0, code} |

## Verification
The hardest case to reach from the ports is a debounce pair that is split by samples for other slots. A related case is a pair whose raw nibbles differ only in bits the current mode discards. Random traffic alone seldom produces either. Directed sequences therefore interleave a second slot between the two matching samples, insert invalid cycles carrying misleading codes, and send near-duplicate nibbles in 2-state and 4-state mode. After that, a long random phase uses a narrow slot range and a small code alphabet so that repeats are frequent, while mode and debounce are toggled now and then.

// File: rtl/sig_store_pkg.sv
package sig_store_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_PAIR  = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_ONE   = 2'b11
  } sig_mode_e;

  // Bits of the code kept in each state mode.
  function automatic logic [CODE_W-1:0] mode_keep(input logic [1:0] mode);
    logic [CODE_W-1:0] keep;
    case (mode)
      MODE_FULL: keep = 4'b1111;
      MODE_PAIR: keep = 4'b0011;
      default:   keep = 4'b0001;
    endcase
    return keep;
  endfunction

endpackage

// File: rtl/sig_rst_sync.sv
module sig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/sig_mode_mask.sv
module sig_mode_mask
  import sig_store_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] keep;

  always_comb begin
    keep   = mode_keep(mode_i);
    code_o = code_i & keep;
  end

endmodule

// File: rtl/sig_debounce_ctl.sv
module sig_debounce_ctl
  import sig_store_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CODE_W-1:0] code_m_i,
  input  logic              deb_en_i,
  output logic              wr_en_o
);

  localparam int DEPTH = 1 << SLOT_W;

  logic [CODE_W-1:0] last_q [DEPTH];
  logic [CODE_W-1:0] last_d [DEPTH];
  logic              match;

  always_comb begin
    match   = (code_m_i == last_q[slot_i]);
    wr_en_o = valid_i && (!deb_en_i || match);
    for (int i = 0; i < DEPTH; i++) begin
      last_d[i] = last_q[i];
    end
    if (valid_i) begin
      last_d[slot_i] = code_m_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        last_q[i] <= '0;
      end
    end else if (valid_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        last_q[i] <= last_d[i];
      end
    end
  end

  // R10
  idle_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> last_q[$past(slot_i)] == $past(last_q[slot_i]));

  // R11
  last_tracks_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> last_q[$past(slot_i)] == $past(code_m_i));

  // R7
  deb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && deb_en_i) |-> (code_m_i == last_q[slot_i]));

endmodule

// File: rtl/sig_code_array.sv
module sig_code_array
  import sig_store_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [1:0]        mode_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [CODE_W+2:0] rd_data_o
);

  localparam int DEPTH = 1 << SLOT_W;

  logic [CODE_W-1:0] code_q [DEPTH];
  logic [CODE_W-1:0] code_d [DEPTH];
  logic [CODE_W+2:0] rd_d;
  logic [CODE_W+2:0] rd_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      code_d[i] = code_q[i];
    end
    if (wr_en_i) begin
      code_d[wr_slot_i] = wr_code_i;
    end
    rd_d = {mode_i, 1'b0, code_q[rd_slot_i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_q[i] <= code_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> code_q[$past(wr_slot_i)] == $past(wr_code_i));

  // R9
  read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_data_o[CODE_W-1:0] == $past(code_q[rd_slot_i]));

  // R5
  read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_data_o[CODE_W+2:CODE_W+1] == $past(mode_i));

  // R4
  write_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (wr_code_i & ~mode_keep(mode_i)) == '0);

endmodule

// File: rtl/sig_code_store.sv
module sig_code_store
  import sig_store_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    mode_i,
  input  logic                          debounce_en_i,
  input  logic                          in_valid_i,
  input  logic [$clog2(NUM_SLOTS)-1:0]  in_slot_i,
  input  logic [3:0]                    in_code_i,
  input  logic [$clog2(NUM_SLOTS)-1:0]  rd_slot_i,
  output logic [6:0]                    rd_data_o
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic              rst_sync_n;
  logic [CODE_W-1:0] code_m;
  logic              wr_en;

  sig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sig_mode_mask u_mask (
    .mode_i (mode_i),
    .code_i (in_code_i),
    .code_o (code_m)
  );

  sig_debounce_ctl #(.SLOT_W(SLOT_W)) u_deb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .valid_i  (in_valid_i),
    .slot_i   (in_slot_i),
    .code_m_i (code_m),
    .deb_en_i (debounce_en_i),
    .wr_en_o  (wr_en)
  );

  sig_code_array #(.SLOT_W(SLOT_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_slot_i (in_slot_i),
    .wr_code_i (code_m),
    .mode_i    (mode_i),
    .rd_slot_i (rd_slot_i),
    .rd_data_o (rd_data_o)
  );

  // R6
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid_i && !debounce_en_i) |-> wr_en);

  // R10
  no_valid_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid_i |-> !wr_en);

endmodule

// File: tb/sig_code_store_tb.sv
module sig_code_store_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       deb;
  logic       in_valid;
  logic [4:0] in_slot;
  logic [3:0] in_code;
  logic [4:0] rd_slot;
  logic [6:0] rd_data;

  int checks = 0;
  int fails  = 0;

  logic [3:0] m_store [32];
  logic [3:0] m_last  [32];

  always #10 clk = ~clk;

  sig_code_store u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .debounce_en_i (deb),
    .in_valid_i    (in_valid),
    .in_slot_i     (in_slot),
    .in_code_i     (in_code),
    .rd_slot_i     (rd_slot),
    .rd_data_o     (rd_data)
  );

  function automatic logic [3:0] keep_f(input logic [1:0] m, input logic [3:0] c);
    if (m == 2'b00) return c;
    if (m == 2'b01) return c & 4'b0011;
    return c & 4'b0001;
  endfunction

  task automatic chk(input logic [6:0] act, input logic [6:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive one cycle, then check the read at the next negedge.
  task automatic step(input logic v, input logic [4:0] s, input logic [3:0] c,
                      input logic [4:0] rs, input string req);
    logic [6:0] exp;
    logic [3:0] mc;
    in_valid = v;
    in_slot  = s;
    in_code  = c;
    rd_slot  = rs;
    exp = {mode, 1'b0, m_store[rs]};
    if (v) begin
      mc = keep_f(mode, c);
      if (!deb || mc == m_last[s]) m_store[s] = mc;
      m_last[s] = mc;
    end
    @(negedge clk);
    chk(rd_data, exp, req);
  endtask

  task automatic rd(input logic [4:0] rs, input string req);
    step(1'b0, 5'd0, 4'hF, rs, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) begin
      m_store[i] = '0;
      m_last[i]  = '0;
    end
    rst_n = 1'b0; mode = 2'b00; deb = 1'b0;
    in_valid = 1'b0; in_slot = '0; in_code = '0; rd_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: every slot reads zero after reset
    for (int i = 0; i < 32; i++) rd(5'(i), "R1");

    // R2: 16-state keeps all bits; R6: immediate write
    step(1'b1, 5'd3, 4'b1010, 5'd3, "R9");
    rd(5'd3, "R2");
    step(1'b1, 5'd4, 4'b0101, 5'd0, "R6");
    rd(5'd4, "R6");
    // R3: 4-state
    mode = 2'b01;
    step(1'b1, 5'd5, 4'b1110, 5'd5, "R5");
    rd(5'd5, "R3");
    // R4: 2-state and mode 10
    mode = 2'b11;
    step(1'b1, 5'd6, 4'b1111, 5'd6, "R9");
    rd(5'd6, "R4");
    mode = 2'b10;
    step(1'b1, 5'd7, 4'b1110, 5'd7, "R4");
    rd(5'd7, "R4");
    rd(5'd3, "R5");

    // R7: debounce pairs, split by another slot
    mode = 2'b00; deb = 1'b1;
    step(1'b1, 5'd10, 4'b1001, 5'd10, "R7");
    rd(5'd10, "R7");
    step(1'b1, 5'd11, 4'b0110, 5'd10, "R7");
    step(1'b1, 5'd10, 4'b1001, 5'd10, "R7");
    rd(5'd10, "R7");
    rd(5'd11, "R7");
    // R7: alternating codes never update
    step(1'b1, 5'd12, 4'b0011, 5'd12, "R7");
    step(1'b1, 5'd12, 4'b1100, 5'd12, "R7");
    step(1'b1, 5'd12, 4'b0011, 5'd12, "R7");
    rd(5'd12, "R7");
    // R10: invalid cycles with other codes do not disturb the pair
    step(1'b1, 5'd13, 4'b0111, 5'd13, "R10");
    step(1'b0, 5'd13, 4'b1000, 5'd13, "R10");
    step(1'b0, 5'd13, 4'b1000, 5'd13, "R10");
    step(1'b1, 5'd13, 4'b0111, 5'd13, "R10");
    rd(5'd13, "R10");
    // R8: masked-off bit changes count as the same code
    mode = 2'b11;
    step(1'b1, 5'd14, 4'b1111, 5'd14, "R8");
    step(1'b1, 5'd14, 4'b0001, 5'd14, "R8");
    rd(5'd14, "R8");
    mode = 2'b01;
    step(1'b1, 5'd15, 4'b0110, 5'd15, "R8");
    step(1'b1, 5'd15, 4'b1010, 5'd15, "R8");
    rd(5'd15, "R8");
    // R11: last-seen tracked while debounce off
    deb = 1'b0; mode = 2'b00;
    step(1'b1, 5'd16, 4'b1011, 5'd16, "R11");
    step(1'b1, 5'd16, 4'b0100, 5'd16, "R11");
    deb = 1'b1;
    step(1'b1, 5'd16, 4'b0100, 5'd16, "R11");
    rd(5'd16, "R11");

    // Random phase: narrow slots and codes for frequent repeats
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 64) == 0) mode = 2'($urandom);
      if (($urandom % 48) == 0) deb  = 1'($urandom);
      step(1'(($urandom % 4) != 0), 5'($urandom % 6), 4'($urandom % 3) | 4'(($urandom % 2) << 3),
           5'($urandom % 6), "R7");
    end
    for (int i = 0; i < 32; i++) rd(5'(i), "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule